// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

This block is a watchdog timer with a small register bank. A binary prescaler divides the clock by 2^PRESC_W. Its terminal ticks advance a lapsed-time counter. When the lapsed count reaches a 12-bit period code, the period ends and the watchdog records an overflow. The first overflow raises a sticky interrupt. If a second overflow follows with no refresh in between, the block issues a one-cycle reset request. Software refreshes the watchdog by writing 1 to the clear register. The refresh restarts the period and withdraws the interrupt.

Writes to the enable and period registers are applied only after a fixed synchronization delay of SYNC_CYC cycles. A busy bit is visible while such a write is pending. Writes to the clear register act at once. A separate parity-error input also requests reset, whether or not the timer is running.

The block contains two state machines. The write-synchronizer has the states `S_IDLE` and `S_HOLD`: `S_IDLE` goes to `S_HOLD` on a write to the enable or period register, `S_HOLD` counts down and applies the write, and a fresh write restarts the count. The overflow tracker has the states `W_OFF`, `W_ARMED` and `W_WARN`:
- `W_OFF` goes to `W_ARMED` when the enable takes effect.
- `W_ARMED` goes to `W_WARN` on an overflow.
- `W_WARN` goes to `W_ARMED` on a second overflow, which fires reset, or on a refresh.
- Every state goes to `W_OFF` when the enable drops.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset every register reads 0, and irq, rst_req and busy are all 0.
- R2: The register map decodes reg_addr[3:2]. Offset 0x0 is control: bit0 is the applied enable and bit1 is busy. Offset 0x4 is the period: the code sits in bits 31:20, bits 19:0 are ignored on write and read as 0. Offset 0x8 reads the lapsed count in bits 11:0. Offset 0xC reads the interrupt flag in bit0.
- R3: A write to 0x0 or 0x4 takes effect exactly 3 clock edges after the write edge, and busy reads 1 during those 3 cycles.
- R4: After the enable takes effect, irq rises after (code+1)·2^PRESC_W clock cycles.
- R5: A second overflow with no refresh after the first drives rst_req high for exactly one cycle and clears irq.
- R6: Writing 0xC with bit0=1 clears the prescaler, the lapsed count and irq at the next edge, without the sync delay. Writing bit0=0 has no effect.
- R7: While running, the lapsed count equals the number of prescaler ticks since the period started.
- R8: Clearing the enable clears the prescaler, the lapsed count and irq, and no reset request follows while disabled.
- R9: rst_req is high in the cycle after par_err is sampled high, whether or not the timer is enabled.
- R10: A refresh between two overflows prevents the reset. The next overflow again only raises irq, one full period after the refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| par_err | input | 1 | CPU parity-error indication |
| irq | output | 1 | Sticky first-overflow interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench measures the interval to irq and to rst_req for several period codes, including code 0. An off-by-one in the prescaler or in the lapsed compare would move both edges by a whole tick. The bench checks that busy spans three cycles and that the enable is not yet visible on the third. A synchronizer with a wrong pipeline depth would fail that check. A refresh between overflows must hold off the reset, and a write of 0 to the clear register must not act as a refresh. A tracker that counts overflows without being cleared by the refresh would fire reset early. Disabling must stop all activity, and the parity input must reach rst_req even while the timer is off.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 32;
    localparam int CODE_W = 12;
    localparam int CODE_LSB = DATA_W - CODE_W;

    typedef enum logic [1:0] {
        OFS_CTRL  = 2'd0,
        OFS_SET   = 2'd1,
        OFS_LAPSE = 2'd2,
        OFS_CLR   = 2'd3
    } reg_ofs_e;

    typedef enum logic {
        S_IDLE,
        S_HOLD
    } sync_st_e;

    typedef enum logic [1:0] {
        W_OFF,
        W_ARMED,
        W_WARN
    } wd_st_e;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync
    import wdt_pkg::*;
#(
    parameter int SYNC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_set,
    input  logic              wr_en_bit,
    input  logic [CODE_W-1:0] wr_code,
    output logic              en_q,
    output logic [CODE_W-1:0] code_q,
    output logic              busy
);
    localparam int CNT_W = $clog2(SYNC_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SYNC_CYC - 1);

    sync_st_e          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              pend_ctrl_q, pend_set_q;
    logic              pend_en_q;
    logic [CODE_W-1:0] pend_code_q;
    logic              any_wr;
    logic              apply;

    assign any_wr = wr_ctrl | wr_set;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (any_wr) st_d = S_HOLD;
            S_HOLD: if (!any_wr && cnt_q == '0) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    assign apply = (st_q == S_HOLD) && !any_wr && (cnt_q == '0);
    assign busy  = (st_q == S_HOLD);

    // countdown, pending values and applied outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            pend_ctrl_q <= 1'b0;
            pend_set_q  <= 1'b0;
            pend_en_q   <= 1'b0;
            pend_code_q <= '0;
            en_q        <= 1'b0;
            code_q      <= '0;
        end else begin
            if (any_wr) begin
                cnt_q <= CNT_LOAD;
                if (wr_ctrl) begin
                    pend_ctrl_q <= 1'b1;
                    pend_en_q   <= wr_en_bit;
                end
                if (wr_set) begin
                    pend_set_q  <= 1'b1;
                    pend_code_q <= wr_code;
                end
            end else if (apply) begin
                if (pend_ctrl_q) en_q   <= pend_en_q;
                if (pend_set_q)  code_q <= pend_code_q;
                pend_ctrl_q <= 1'b0;
                pend_set_q  <= 1'b0;
            end else if (st_q == S_HOLD) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
    import wdt_pkg::*;
#(
    parameter int PRESC_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              refresh,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] lapsed,
    output logic              ovf
);
    logic [PRESC_W-1:0] presc_q;
    logic               tick;

    assign tick = en && (presc_q == {PRESC_W{1'b1}});
    assign ovf  = tick && (lapsed >= code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            lapsed  <= '0;
        end else if (!en || refresh) begin
            presc_q <= '0;
            lapsed  <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
            if (ovf)       lapsed <= '0;
            else if (tick) lapsed <= lapsed + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic refresh,
    input  logic ovf,
    output logic warn,
    output logic fire
);
    wd_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_OFF:   if (en) st_d = W_ARMED;
            W_ARMED: if (!en) st_d = W_OFF;
                     else if (ovf && !refresh) st_d = W_WARN;
            W_WARN:  if (!en) st_d = W_OFF;
                     else if (refresh || ovf) st_d = W_ARMED;
            default: st_d = W_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= W_OFF;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        warn = (st_q == W_WARN);
        fire = (st_q == W_WARN) && en && ovf && !refresh;
    end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int PRESC_W  = 20,
    parameter int SYNC_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        par_err,
    output logic        irq,
    output logic        rst_req
);
    reg_ofs_e          ofs;
    logic              wr_ctrl, wr_set, refresh;
    logic              en_q, busy;
    logic [CODE_W-1:0] code_q, lapsed;
    logic              ovf, fire, warn;
    logic              unused_bits;

    assign ofs     = reg_ofs_e'(reg_addr[3:2]);
    assign wr_ctrl = reg_wr && (ofs == OFS_CTRL);
    assign wr_set  = reg_wr && (ofs == OFS_SET);
    assign refresh = reg_wr && (ofs == OFS_CLR) && reg_wdata[0];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[CODE_LSB-1:1]};

    wdt_sync #(.SYNC_CYC(SYNC_CYC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_set    (wr_set),
        .wr_en_bit (reg_wdata[0]),
        .wr_code   (reg_wdata[DATA_W-1:CODE_LSB]),
        .en_q      (en_q),
        .code_q    (code_q),
        .busy      (busy)
    );

    wdt_timebase #(.PRESC_W(PRESC_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .refresh (refresh),
        .code    (code_q),
        .lapsed  (lapsed),
        .ovf     (ovf)
    );

    wdt_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .refresh (refresh),
        .ovf     (ovf),
        .warn    (warn),
        .fire    (fire)
    );

    assign irq = warn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= fire | par_err;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (ofs)
            OFS_CTRL:  reg_rdata[1:0] = {busy, en_q};
            OFS_SET:   reg_rdata[DATA_W-1:CODE_LSB] = code_q;
            OFS_LAPSE: reg_rdata[CODE_W-1:0] = lapsed;
            OFS_CLR:   reg_rdata[0] = warn;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        par_err,
    input logic        irq,
    input logic        rst_req,
    input logic        busy,
    input logic        en_q
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9
    parity_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(par_err)) |-> rst_req);

    // R5
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rst_req && !$past(par_err)) |-> $past(irq));

    // R5
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !par_err) |=> !rst_req);

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !irq);

    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr[3:2] == 2'd0 || reg_addr[3:2] == 2'd1)) |=> busy);

    // R6
    refresh_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[3:2] == 2'd3 && reg_wdata[0]) |=> !irq);
endmodule

bind wdt_two_stage wdt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .par_err   (par_err),
    .irq       (irq),
    .rst_req   (rst_req),
    .busy      (busy),
    .en_q      (en_q)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
    localparam int PW = 4;
    localparam int TICK = 1 << PW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        par_err = 1'b0;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    wdt_two_stage #(.PRESC_W(PW), .SYNC_CYC(3)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .par_err(par_err),
        .irq(irq), .rst_req(rst_req)
    );

    // {refresh-between-overflows, code}
    localparam logic [12:0] VEC [4] = '{
        {1'b0, 12'd0}, {1'b0, 12'd2}, {1'b1, 12'd1}, {1'b0, 12'd5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        rd(4'h0, v);
        while (v[1]) begin
            @(negedge clk);
            rd(4'h0, v);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n, m;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), v);
            chk("R1 reg after reset", v, 0);
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);

        // R2 low setting bits ignored
        wr(4'h4, 32'hFFFF_FFFF);
        wait_idle();
        rd(4'h4, v);
        chk("R2 setting readback", v, 32'hFFF0_0000);

        // R3 sync delay and busy window
        wr(4'h0, 32'h1);
        rd(4'h0, v); chk("R3 busy cycle1", v, 32'h2);
        @(negedge clk); rd(4'h0, v); chk("R3 busy cycle2", v, 32'h2);
        @(negedge clk); rd(4'h0, v); chk("R3 busy cycle3 not applied", v, 32'h2);
        @(negedge clk); rd(4'h0, v); chk("R3 applied", v, 32'h1);
        wr(4'h0, 32'h0);
        wait_idle();

        // table: R4 period, R5 second overflow, R10 refresh
        foreach (VEC[i]) begin
            int c, per;
            c = int'(VEC[i][11:0]);
            per = (c + 1) * TICK;
            wr(4'h4, {VEC[i][11:0], 20'h0});
            wr(4'h0, 32'h1);
            wait_idle();
            n = 0;
            while (!irq && n < 4 * per) begin @(negedge clk); n++; end
            chk("R4 cycles to irq", n, per);
            if (VEC[i][12]) begin
                wr(4'hC, 32'h1);
                chk("R6 irq cleared by refresh", {31'b0, irq}, 0);
                n = 0; seen = 1'b0;
                while (!irq && n < 4 * per) begin
                    @(negedge clk); n++;
                    if (rst_req) seen = 1'b1;
                end
                chk("R10 irq again after refresh", n, per);
                chk("R10 no reset after refresh", {31'b0, seen}, 0);
            end
            m = 0;
            while (!rst_req && m < 4 * per) begin @(negedge clk); m++; end
            chk("R5 cycles irq to rst_req", m, per);
            chk("R5 irq cleared at rst", {31'b0, irq}, 0);
            @(negedge clk);
            chk("R5 rst_req one cycle", {31'b0, rst_req}, 0);
            wr(4'h0, 32'h0);
            wait_idle();
        end

        // R7 lapsed count
        wr(4'h4, {12'd3, 20'h0});
        wr(4'h0, 32'h1);
        wait_idle();
        repeat (40) @(negedge clk);
        rd(4'h8, v);
        chk("R7 lapsed after 40 cycles", v, 2);

        // R6 write of 0 has no effect, then 1 clears at once
        while (!irq) @(negedge clk);
        wr(4'hC, 32'h0);
        rd(4'hC, v);
        chk("R6 zero write ignored", v, 1);
        wr(4'hC, 32'h1);
        rd(4'hC, v);
        chk("R6 refresh clears flag", v, 0);
        rd(4'h8, v);
        chk("R6 refresh clears lapsed", v, 0);

        // R8 disable while warned
        while (!irq) @(negedge clk);
        wr(4'h0, 32'h0);
        wait_idle();
        @(negedge clk);
        chk("R8 irq off after disable", {31'b0, irq}, 0);
        rd(4'h8, v);
        chk("R8 lapsed cleared", v, 0);
        seen = 1'b0;
        repeat (300) begin @(negedge clk); if (rst_req || irq) seen = 1'b1; end
        chk("R8 quiet while disabled", {31'b0, seen}, 0);

        // R9 parity error while disabled
        par_err = 1'b1;
        @(negedge clk);
        par_err = 1'b0;
        chk("R9 parity reset", {31'b0, rst_req}, 1);
        @(negedge clk);
        chk("R9 parity pulse ends", {31'b0, rst_req}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule